// File: doc/BRIEF.md
# Shared-Pin Serial Configuration Port

This block is a write-only, three-wire configuration port whose clock and data lines reuse two pins that otherwise carry output data. An active-low select decides the role of the pins. While the select is low, the block releases both pins and treats them as a serial clock and a serial data input. While the select is high, it drives the core's output data onto them. The serial clock, data and select are asynchronous to the system clock. They are brought into the system clock domain by synchronisers and oversampled there, so the whole block runs on one clock.

Each write is a 16-bit frame sent MSB first. The frame carries four leading zero bits, then a 4-bit address, then 8 data bits. The block shifts a bit in on every rising edge of the serial clock and counts the edges, saturating at 16. When the select returns high, it decodes the last 16 bits shifted in and writes the addressed register.

The register file has four parts:
- a mode register;
- one offset register for each of three channels;
- one gain register for each of three channels;
- a two-bit DC-coupled mode field.

The block discards a frame in four cases: fewer than 16 edges arrived, a leading bit is not zero, the address is out of range, or the address falls in the reserved test range. It drops any data bit beyond the width of the target register.

Top module: `serial_cfg_port`

## Requirements
- R1: After the reset input is sampled low, every register output is zero. Once the select is high, the pin output enable is high.
- R2: While the select is low, the pin output enable is low and the pin outputs are zero. While the output enable is high, the pin outputs equal the core data inputs.
- R3: The frame is sampled on rising edges of the serial clock (pin input bit 0), with data taken from pin input bit 1, MSB first. Frame bits 15:12 must be zero, bits 11:8 are the address and bits 7:0 are the data.
- R4: If more than 16 rising edges occur in one select-low window, the last 16 bits form the frame.
- R5: If fewer than 16 rising edges occur in one select-low window, no register changes.
- R6: A frame whose bits 15:12 are not all zero changes no register.
- R7: A frame with an address from 8 to 15 (the test range and above) changes no register.
- R8: Address 0 writes the mode register: test flag = data bit 6, narrow-bus flag = bit 5, wide-range flag = bit 4, invert flag = bit 3, operating mode = bits 2:0. Data bit 7 is dropped.
- R9: Addresses 1, 2 and 3 write the full 8-bit offset of channels 0, 1 and 2. The offset of channel c sits at cfg_offset bits 8c+7:8c.
- R10: Addresses 4, 5 and 6 write the 7-bit gain of channels 0, 1 and 2 from data bits 6:0, dropping bit 7. The gain of channel c sits at cfg_gain bits 7c+6:7c.
- R11: Address 7 writes the DC-coupled mode field from data bits 1:0. The other data bits are dropped.
- R12: A write appears on the outputs at the third rising system-clock edge after the select rises, and not earlier. Outside a write, all register outputs hold their values, and a write changes only one register.
- R13: After the select rises, the pin output enable stays low until the second rising system-clock edge and is high after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en_n | input | 1 | Active-low port select, asynchronous |
| pad_i | input | 2 | Sensed shared pins: bit 0 serial clock, bit 1 serial data |
| core_d | input | 2 | Core data to drive on the shared pins |
| pad_o | output | 2 | Data driven on the shared pins |
| pad_oe | output | 1 | Output enable of the shared pins |
| cfg_test | output | 1 | Mode register test flag |
| cfg_bus_narrow | output | 1 | Mode register narrow-bus flag |
| cfg_range_wide | output | 1 | Mode register wide-range flag |
| cfg_invert | output | 1 | Mode register input-invert flag |
| cfg_op_mode | output | 3 | Mode register operating mode |
| cfg_offset | output | 24 | Channel offsets, channel 0 in the low byte |
| cfg_gain | output | 21 | Channel gains, channel 0 in the low 7 bits |
| cfg_direct | output | 2 | DC-coupled mode field |

## Verification
A write becomes visible at the third rising system-clock edge after the select goes high. Two edges go to the synchroniser and one to the register write. The bench therefore waits six cycles before it compares the registers against its model. A directed case samples after the first, second and third edges to pin down that cycle exactly.

The output enable falls as soon as the select falls. It rises again after the second edge, and the bench samples it after each of the first two edges. Serial data is set two system cycles before each serial-clock rise and held for six cycles after it, so the synchronised data and clock arrive together. All sampling happens on falling system-clock edges.

// File: rtl/serial_cfg_pkg.sv
// Package: frame layout, register field types and helpers for the serial
// configuration port. Assumes a frame of lead bits, address and data, MSB first.
package serial_cfg_pkg;

    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int LEAD_W  = FRAME_W - ADDR_W - DATA_W;
    localparam int MODE_W  = 7;
    localparam int DIR_W   = 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [LEAD_W-1:0] lead;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic       test;
        logic       bus_narrow;
        logic       range_wide;
        logic       invert;
        logic [2:0] op_mode;
    } mode_t;

    localparam logic [ADDR_W-1:0] ADR_MODE = '0;

    // A frame is accepted when its lead bits are clear and the address is mapped
    function automatic logic frame_ok(input frame_t f, input logic [ADDR_W-1:0] last_adr);
        return (f.lead == '0) && (f.addr <= last_adr);
    endfunction

endpackage

// File: rtl/scp_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; the reset value sets the idle level.
module scp_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Stage 0 samples the raw inputs
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= async_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage re-samples the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/scp_shifter.sv
// Module: frame shifter. Detects rising serial-clock edges in the system
// domain, shifts data MSB first and counts edges, saturating at the frame
// width. Assumes the inputs are already synchronised.
module scp_shifter #(
    parameter int FRAME_W = 16,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdata_s,
    input  logic               idle_s,
    output logic [FRAME_W-1:0] frame_q,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               frame_full,
    output logic               idle_rise
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    logic sclk_d;
    logic idle_d;
    logic sclk_rise;

    assign sclk_rise  = sclk_s & ~sclk_d;
    assign idle_rise  = idle_s & ~idle_d;
    assign frame_full = (bit_cnt == FULL_CNT);

    // Previous samples for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            idle_d <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            idle_d <= idle_s;
        end
    end

    // Shift on each serial-clock rise while selected; the oldest bits fall out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (!idle_s && sclk_rise) begin
            frame_q <= {frame_q[FRAME_W-2:0], sdata_s};
        end
    end

    // Edge counter: cleared while idle, saturates at the frame width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (idle_s) begin
            bit_cnt <= '0;
        end else if (sclk_rise && !frame_full) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/scp_regfile.sv
// Module: configuration register file. Mode at address 0, per-channel
// offsets then gains, then the DC-coupled field at the last address.
// Assumes the address has been range-checked; data bits above each field width are dropped.
module scp_regfile
    import serial_cfg_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int OFF_W  = 8,
    parameter int GAIN_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output mode_t                    mode_q,
    output logic [NUM_CH*OFF_W-1:0]  off_q,
    output logic [NUM_CH*GAIN_W-1:0] gain_q,
    output logic [DIR_W-1:0]         dir_q
);

    localparam logic [ADDR_W-1:0] ADR_DIR = ADDR_W'(2 * NUM_CH + 1);

    // Mode register write
    always_ff @(posedge clk) begin
        if (!rst_n)                             mode_q <= '0;
        else if (wr_en && wr_addr == ADR_MODE)  mode_q <= mode_t'(wr_data[MODE_W-1:0]);
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
            localparam logic [ADDR_W-1:0] ADR_OFF  = ADDR_W'(1 + ch);
            localparam logic [ADDR_W-1:0] ADR_GAIN = ADDR_W'(1 + NUM_CH + ch);

            // Channel offset write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    off_q[ch*OFF_W +: OFF_W] <= '0;
                else if (wr_en && wr_addr == ADR_OFF)
                    off_q[ch*OFF_W +: OFF_W] <= wr_data[OFF_W-1:0];
            end

            // Channel gain write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    gain_q[ch*GAIN_W +: GAIN_W] <= '0;
                else if (wr_en && wr_addr == ADR_GAIN)
                    gain_q[ch*GAIN_W +: GAIN_W] <= wr_data[GAIN_W-1:0];
            end
        end
    endgenerate

    // DC-coupled field write
    always_ff @(posedge clk) begin
        if (!rst_n)                            dir_q <= '0;
        else if (wr_en && wr_addr == ADR_DIR)  dir_q <= wr_data[DIR_W-1:0];
    end

endmodule

// File: rtl/serial_cfg_port.sv
// Module: shared-pin serial configuration port (top). Releases the two shared
// pins while selected, oversamples the serial clock and data, and commits a
// frame to the register file when the synchronised select rises.
// Assumes the serial clock is much slower than the system clock (4+ cycles per phase).
module serial_cfg_port
    import serial_cfg_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int OFF_W       = 8,
    parameter int GAIN_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_en_n,
    input  logic [1:0]               pad_i,
    input  logic [1:0]               core_d,
    output logic [1:0]               pad_o,
    output logic                     pad_oe,
    output logic                     cfg_test,
    output logic                     cfg_bus_narrow,
    output logic                     cfg_range_wide,
    output logic                     cfg_invert,
    output logic [2:0]               cfg_op_mode,
    output logic [NUM_CH*OFF_W-1:0]  cfg_offset,
    output logic [NUM_CH*GAIN_W-1:0] cfg_gain,
    output logic [DIR_W-1:0]         cfg_direct
);

    localparam logic [ADDR_W-1:0] LAST_ADR = ADDR_W'(2 * NUM_CH + 1);

    logic               idle_s;
    logic               sclk_s;
    logic               sdata_s;
    logic [FRAME_W-1:0] frame_w;
    logic [CNT_W-1:0]   bit_cnt_w;
    logic               full_w;
    logic               idle_rise_w;
    logic               commit_w;
    frame_t             frame_f;
    mode_t              mode_w;

    scp_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pad_i[1], pad_i[0], cfg_en_n}),
        .sync_o  ({sdata_s, sclk_s, idle_s})
    );

    scp_shifter #(
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .sdata_s    (sdata_s),
        .idle_s     (idle_s),
        .frame_q    (frame_w),
        .bit_cnt    (bit_cnt_w),
        .frame_full (full_w),
        .idle_rise  (idle_rise_w)
    );

    // Commit a complete, well-formed frame when the select returns high
    assign frame_f  = frame_t'(frame_w);
    assign commit_w = idle_rise_w & full_w & frame_ok(frame_f, LAST_ADR);

    scp_regfile #(
        .NUM_CH (NUM_CH),
        .OFF_W  (OFF_W),
        .GAIN_W (GAIN_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_w),
        .wr_addr (frame_f.addr),
        .wr_data (frame_f.data),
        .mode_q  (mode_w),
        .off_q   (cfg_offset),
        .gain_q  (cfg_gain),
        .dir_q   (cfg_direct)
    );

    // Pins drop off at once on select; they drive again only once the synchronised select is idle
    assign pad_oe = cfg_en_n & idle_s;
    assign pad_o  = pad_oe ? core_d : 2'b00;

    assign cfg_test       = mode_w.test;
    assign cfg_bus_narrow = mode_w.bus_narrow;
    assign cfg_range_wide = mode_w.range_wide;
    assign cfg_invert     = mode_w.invert;
    assign cfg_op_mode    = mode_w.op_mode;

endmodule

// File: rtl/serial_cfg_port_chk.sv
// Module: assertion checker for serial_cfg_port, attached by bind.
// Assumes the same parameters as the top module.
module serial_cfg_port_chk #(
    parameter int NUM_CH  = 3,
    parameter int OFF_W   = 8,
    parameter int GAIN_W  = 7,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_en_n,
    input logic [1:0]               core_d,
    input logic [1:0]               pad_o,
    input logic                     pad_oe,
    input logic                     commit,
    input logic [CNT_W-1:0]         bit_cnt,
    input logic [6:0]               mode_bits,
    input logic [NUM_CH*OFF_W-1:0]  offs,
    input logic [NUM_CH*GAIN_W-1:0] gains,
    input logic [1:0]               direct
);

    logic [6:0]               mode_p;
    logic [NUM_CH*OFF_W-1:0]  offs_p;
    logic [NUM_CH*GAIN_W-1:0] gains_p;
    logic [1:0]               direct_p;
    logic [2*NUM_CH+1:0]      chg;

    // Register outputs one cycle back, for change detection
    always_ff @(posedge clk) begin
        mode_p   <= mode_bits;
        offs_p   <= offs;
        gains_p  <= gains;
        direct_p <= direct;
    end

    // One change flag per register
    always_comb begin
        chg = '0;
        chg[0] = (mode_bits != mode_p);
        for (int c = 0; c < NUM_CH; c++) begin
            chg[1 + c]          = (offs[c*OFF_W +: OFF_W] != offs_p[c*OFF_W +: OFF_W]);
            chg[1 + NUM_CH + c] = (gains[c*GAIN_W +: GAIN_W] != gains_p[c*GAIN_W +: GAIN_W]);
        end
        chg[2*NUM_CH+1] = (direct != direct_p);
    end

    assert_pins_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en_n |-> (!pad_oe && pad_o == 2'b00));

    assert_pins_drive_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> (pad_o == core_d));

    assert_regs_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (chg == '0));

    assert_single_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ($countones(chg) <= 1));

    assert_count_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W));

endmodule

bind serial_cfg_port serial_cfg_port_chk #(
    .NUM_CH  (NUM_CH),
    .OFF_W   (OFF_W),
    .GAIN_W  (GAIN_W),
    .FRAME_W (serial_cfg_pkg::FRAME_W),
    .CNT_W   (serial_cfg_pkg::CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en_n  (cfg_en_n),
    .core_d    (core_d),
    .pad_o     (pad_o),
    .pad_oe    (pad_oe),
    .commit    (commit_w),
    .bit_cnt   (bit_cnt_w),
    .mode_bits ({cfg_test, cfg_bus_narrow, cfg_range_wide, cfg_invert, cfg_op_mode}),
    .offs      (cfg_offset),
    .gains     (cfg_gain),
    .direct    (cfg_direct)
);

// File: tb/serial_cfg_port_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random frames against a register model.
module serial_cfg_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en_n = 1'b1;
    logic [1:0]  pad_i = 2'b00;
    logic [1:0]  core_d = 2'b00;
    logic [1:0]  pad_o;
    logic        pad_oe;
    logic        cfg_test, cfg_bus_narrow, cfg_range_wide, cfg_invert;
    logic [2:0]  cfg_op_mode;
    logic [23:0] cfg_offset;
    logic [20:0] cfg_gain;
    logic [1:0]  cfg_direct;

    int total = 0;
    int bad = 0;
    logic [53:0] exp_st = '0;
    logic [53:0] obs;

    always #5 clk = ~clk;

    serial_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .cfg_en_n(cfg_en_n), .pad_i(pad_i), .core_d(core_d),
        .pad_o(pad_o), .pad_oe(pad_oe), .cfg_test(cfg_test), .cfg_bus_narrow(cfg_bus_narrow),
        .cfg_range_wide(cfg_range_wide), .cfg_invert(cfg_invert), .cfg_op_mode(cfg_op_mode),
        .cfg_offset(cfg_offset), .cfg_gain(cfg_gain), .cfg_direct(cfg_direct)
    );

    assign obs = {cfg_test, cfg_bus_narrow, cfg_range_wide, cfg_invert, cfg_op_mode,
                  cfg_offset, cfg_gain, cfg_direct};

    // Model of one accepted frame: layout mode[53:47], offsets[46:23], gains[22:2], dc[1:0]
    function automatic logic [53:0] model_write(input logic [53:0] cur, input logic [15:0] f);
        logic [53:0] r = cur;
        int a = int'(f[11:8]);
        if (f[15:12] != 4'h0) return cur;
        if (a == 0)               r[53:47] = f[6:0];
        else if (a >= 1 && a <= 3) r[23 + (a-1)*8 +: 8] = f[7:0];
        else if (a >= 4 && a <= 6) r[2 + (a-4)*7 +: 7] = f[6:0];
        else if (a == 7)          r[1:0] = f[1:0];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Select low and clock out nbits of val, MSB first; select stays low
    task automatic shift_bits(input int nbits, input logic [31:0] val);
        cfg_en_n = 1'b0;
        tick(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            pad_i[1] = val[i];
            tick(2);
            pad_i[0] = 1'b1;
            tick(3);
            pad_i[0] = 1'b0;
            tick(3);
        end
        tick(2);
    endtask

    // Full write: shift, check released pins, raise select, compare against model
    task automatic send(input int nbits, input logic [31:0] val, input string req);
        shift_bits(nbits, val);
        check("R2 oe low while selected", {63'd0, pad_oe}, 64'd0);
        cfg_en_n = 1'b1;
        tick(6);
        if (nbits >= 16) exp_st = model_write(exp_st, val[15:0]);
        check(req, {10'd0, obs}, {10'd0, exp_st});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] fr;
        logic [31:0] v;
        int r, nb;
        string tag;
        void'($urandom(32'd20240611));
        tick(4);
        rst_n = 1'b1;
        tick(1);
        check("R1 regs zero after reset", {10'd0, obs}, 64'd0);
        check("R1 oe high after reset", {63'd0, pad_oe}, 64'd1);
        core_d = 2'b10;
        #1;
        check("R2 pads follow core", {62'd0, pad_o}, 64'd2);

        // Pins released as soon as select falls
        cfg_en_n = 1'b0;
        #1;
        check("R2 oe drops at once", {62'd0, pad_o, pad_oe}, 64'd0);
        cfg_en_n = 1'b1;
        tick(6);

        // Field placement and masking
        send(16, 32'h0000_00FF, "R8 mode fields, bit7 dropped");
        send(16, 32'h0000_002A, "R8 mode fields pattern");
        send(16, 32'h0000_01A5, "R9 offset ch0");
        send(16, 32'h0000_025A, "R9 offset ch1");
        send(16, 32'h0000_03FF, "R9 offset ch2");
        send(16, 32'h0000_04FF, "R10 gain ch0 bit7 dropped");
        send(16, 32'h0000_0580, "R10 gain ch1 only bit7");
        send(16, 32'h0000_0633, "R10 gain ch2");
        send(16, 32'h0000_07FE, "R11 dc field masked");
        send(20, 32'h000F_0155, "R4 last 16 of 20 bits");
        send(15, 32'h0000_0122, "R5 short frame discarded");
        send(16, 32'h0000_1177, "R6 nonzero lead bits");
        send(16, 32'h0000_0899, "R7 test address 8");
        send(16, 32'h0000_0E11, "R7 test address 14");
        send(16, 32'h0000_0F3C, "R7 address 15");

        // Commit cycle and output-enable return
        shift_bits(16, 32'h0000_02C3);
        cfg_en_n = 1'b1;
        tick(1);
        check("R12 no change after first edge", {10'd0, obs}, {10'd0, exp_st});
        check("R13 oe still low after first edge", {63'd0, pad_oe}, 64'd0);
        tick(1);
        check("R12 no change after second edge", {10'd0, obs}, {10'd0, exp_st});
        check("R13 oe high after second edge", {63'd0, pad_oe}, 64'd1);
        tick(1);
        exp_st = model_write(exp_st, 16'h02C3);
        check("R12 write visible after third edge", {10'd0, obs}, {10'd0, exp_st});

        // Seeded random frames
        for (int n = 0; n < 150; n++) begin
            r  = int'($urandom % 10);
            fr = {4'h0, 4'($urandom % 8), 8'($urandom)};
            nb = 16;
            tag = "R3 random frame";
            if (r == 0) begin fr[15:12] = 4'($urandom % 15 + 1); tag = "R6 random lead"; end
            if (r == 1) begin fr[11:8] = 4'(8 + $urandom % 8);   tag = "R7 random high address"; end
            if (r == 2) begin nb = 8 + int'($urandom % 8);       tag = "R5 random short"; end
            if (r == 3) begin nb = 17 + int'($urandom % 8);      tag = "R4 random long"; end
            v = {16'($urandom), fr};
            core_d = 2'($urandom);
            send(nb, v, tag);
        end

        // Reset again after writes
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        exp_st = '0;
        check("R1 regs zero after second reset", {10'd0, obs}, 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule